// File: doc/BRIEF.md
# Modem Line Status Register

This block holds the eight-bit status view of a serial port's four modem input lines. It samples carrier detect, ring indicator, data set ready and clear to send through a two-flop synchronizer. The current line levels occupy the upper nibble. The lower nibble holds sticky change flags, which the interrupt logic watches through a single summary output.

A read strobe from the register bus returns the combined value. That read then clears the change flags. The line levels are left as they are.

When the port is in loopback mode, the register shows a fixed remapping of the modem control outputs in place of the line levels. In that mode a read leaves the change flags untouched.

Top module: `modem_status_unit`

## Requirements
- R1: After reset, rdData reads 8'hB0: carrier detect, data set ready and clear to send read 1, ring indicator reads 0, and anyDelta is 0.
- R2: The line levels appear on rdData bits 7:4 two clock edges after they change on lineIn. Bit order, high to low: carrier (lineIn[3]), ring (lineIn[2]), data set ready (lineIn[1]), clear to send (lineIn[0]).
- R3: A change of level on carrier, data set ready or clear to send sets that line's flag. Carrier sets bit 3, data set ready bit 1 and clear to send bit 0. The flag is set on the same edge that the new level appears, and it stays set until a normal-mode read.
- R4: The ring flag (bit 2) is set only when the ring level falls from 1 to 0. A rising ring level sets no flag.
- R5: With loopMode low, a cycle with rdStrobe high shows the pre-clear value on rdData. After that clock edge, bits 3:0 are 0 and bits 7:4 are unchanged.
- R6: With loopMode high, rdData reads as follows: bit 7 is ctrlReg[3], bit 6 is ctrlReg[2], bit 5 is ctrlReg[0], bit 4 is ctrlReg[1], and bits 3:0 are 0.
- R7: A read with loopMode high clears no change flag. The flags are still there once loopMode returns low.
- R8: anyDelta is the OR of the four change flags.
- R9: A line change whose flag is set on the same edge as a normal-mode read keeps that flag after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lineIn | input | 4 | Modem input lines {carrier, ring, data set ready, clear to send} |
| rdStrobe | input | 1 | Register read in this cycle |
| loopMode | input | 1 | Loopback mode select |
| ctrlReg | input | 5 | Modem control register value |
| rdData | output | 8 | Register read value |
| anyDelta | output | 1 | Some change flag is set |

## Verification
The first set of directed patterns toggles each line kind on its own. A clear-to-send toggle separates the two-edge level latency from the flag timing. Rising and then falling ring edges separate the trailing-edge rule from plain change detection. A loopback read followed by a normal read shows both the remapping and that no flags were cleared. A line change timed so that its flag lands on the edge of a read catches a clear that wins over a new flag. Seeded random line flips, interleaved with random reads and loopback toggles, are then compared every cycle against a bench model.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
  localparam int LineCount  = 4;
  localparam int RegWidth   = 2 * LineCount;
  localparam int CtrlWidth  = 5;
  localparam int IdxCarrier = 3;
  localparam int IdxRing    = 2;
  localparam int IdxReady   = 1;
  localparam int IdxClear   = 0;
  localparam logic [LineCount-1:0] ResetLevel = 4'b1011;

  typedef struct packed {
    logic clrDelta;
    logic loopSel;
  } mstat_strb_t;
endpackage

// File: rtl/mstat_ctrl.sv
module mstat_ctrl
  import mstat_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdStrobe,
  input  logic        loopMode,
  output mstat_strb_t strb
);
  always_comb begin
    strb.loopSel  = loopMode;
    strb.clrDelta = rdStrobe && !loopMode;
  end

  // R7
  loop_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    loopMode |-> !strb.clrDelta);
endmodule

// File: rtl/mstat_datapath.sv
module mstat_datapath
  import mstat_pkg::*;
#(
  parameter int SyncDepth = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LineCount-1:0] lineIn,
  input  mstat_strb_t          strb,
  input  logic [CtrlWidth-1:0] ctrlReg,
  output logic [RegWidth-1:0]  rdData,
  output logic                 anyDelta
);
  logic [SyncDepth-1:0][LineCount-1:0] syncQ;
  logic [LineCount-1:0] levelQ, nextLvl, edgeVec, deltaQ;
  logic [RegWidth-1:0]  loopView;
  logic                 unusedCtrl;

  generate
    for (genvar s = 0; s < SyncDepth; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[s] <= ResetLevel;
          else       syncQ[s] <= lineIn;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[s] <= ResetLevel;
          else       syncQ[s] <= syncQ[s-1];
      end
    end
  endgenerate

  assign levelQ  = syncQ[SyncDepth-1];
  assign nextLvl = syncQ[SyncDepth-2];

  generate
    for (genvar b = 0; b < LineCount; b++) begin : g_edge
      if (b == IdxRing) begin : g_trail
        assign edgeVec[b] = levelQ[b] && !nextLvl[b];
      end else begin : g_any
        assign edgeVec[b] = levelQ[b] ^ nextLvl[b];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) deltaQ <= '0;
    else       deltaQ <= (strb.clrDelta ? '0 : deltaQ) | edgeVec;

  assign unusedCtrl = ctrlReg[4];
  assign loopView   = {ctrlReg[3], ctrlReg[2], ctrlReg[0], ctrlReg[1], 4'b0000};
  assign rdData     = strb.loopSel ? loopView : {levelQ, deltaQ};
  assign anyDelta   = |deltaQ;

  // R2
  level_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> levelQ == $past(nextLvl));
  // R3
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrDelta |=> (deltaQ & $past(deltaQ)) == $past(deltaQ));
  // R4
  ring_rise_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(levelQ[IdxRing]) && !$past(deltaQ[IdxRing])) |-> !deltaQ[IdxRing]);
  // R5
  read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrDelta && edgeVec == '0) |=> deltaQ == '0);
  // R9
  change_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrDelta && edgeVec[IdxCarrier]) |=> deltaQ[IdxCarrier]);
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
  import mstat_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] lineIn,
  input  logic       rdStrobe,
  input  logic       loopMode,
  input  logic [4:0] ctrlReg,
  output logic [7:0] rdData,
  output logic       anyDelta
);
  mstat_strb_t strb;

  mstat_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .loopMode(loopMode), .strb(strb)
  );

  mstat_datapath #(.SyncDepth(2)) i_dp (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .strb(strb), .ctrlReg(ctrlReg),
    .rdData(rdData), .anyDelta(anyDelta)
  );

  // R8
  any_delta_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loopMode |-> anyDelta == (rdData[3:0] != 4'h0));
endmodule

// File: tb/test_modem_status_unit.sv
`timescale 1ns/1ps
module test_modem_status_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] lineIn = 4'b1011;
  logic rdStrobe = 1'b0;
  logic loopMode = 1'b0;
  logic [4:0] ctrlReg = '0;
  logic [7:0] rdData;
  logic anyDelta;
  int total = 0;
  int bad = 0;
  logic [3:0] mA, mB, mD;

  always #4 clk = ~clk;

  modem_status_unit i_modem_status_unit (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .rdStrobe(rdStrobe),
    .loopMode(loopMode), .ctrlReg(ctrlReg), .rdData(rdData), .anyDelta(anyDelta)
  );

  function automatic logic [3:0] edgesOf(logic [3:0] nxt, logic [3:0] cur);
    return {nxt[3] ^ cur[3], cur[2] & ~nxt[2], nxt[1] ^ cur[1], nxt[0] ^ cur[0]};
  endfunction

  function automatic logic [7:0] loopMap(logic [4:0] c);
    return {c[3], c[2], c[0], c[1], 4'b0000};
  endfunction

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      mA <= 4'b1011; mB <= 4'b1011; mD <= '0;
    end else begin
      mA <= lineIn;
      mB <= mA;
      mD <= ((rdStrobe && !loopMode) ? 4'h0 : mD) | edgesOf(mA, mB);
    end

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmpModel();
    check("R2/R6 model", rdData, loopMode ? loopMap(ctrlReg) : {mB, mD});
    check("R8 model", {7'b0, anyDelta}, {7'b0, |mD});
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog got=hang exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", rdData, 8'hB0);
    check("R1 anyDelta", {7'b0, anyDelta}, 8'h00);
    rstN = 1'b1;
    step();
    // R2/R3 clear-to-send toggle
    lineIn = 4'b1010;
    step();
    check("R2 latency", rdData, 8'hB0);
    step();
    check("R3", rdData, 8'hA1);
    repeat (3) step();
    check("R3 sticky", rdData, 8'hA1);
    check("R8", {7'b0, anyDelta}, 8'h01);
    // R5 read then clear
    rdStrobe = 1'b1;
    #1 check("R5 pre", rdData, 8'hA1);
    step();
    rdStrobe = 1'b0;
    check("R5 post", rdData, 8'hA0);
    check("R8 clear", {7'b0, anyDelta}, 8'h00);
    // R4 ring edges
    lineIn = 4'b1110;
    step(); step();
    check("R4 rise", rdData, 8'hE0);
    lineIn = 4'b1010;
    step(); step();
    check("R4 fall", rdData, 8'hA4);
    // R6 loopback view, R7 flags kept
    loopMode = 1'b1; ctrlReg = 5'b01101;
    #1 check("R6", rdData, 8'hE0);
    rdStrobe = 1'b1;
    step();
    rdStrobe = 1'b0; loopMode = 1'b0;
    #1 check("R7", rdData, 8'hA4);
    rdStrobe = 1'b1;
    step();
    rdStrobe = 1'b0;
    check("R5 ring clear", rdData, 8'hA0);
    // R9 change lands on read edge
    lineIn = 4'b0010;
    step();
    rdStrobe = 1'b1;
    step();
    rdStrobe = 1'b0;
    check("R9", rdData, 8'h28);
    // random phase against the model
    for (int n = 0; n < 600; n++) begin
      cmpModel();
      if ($urandom_range(3) == 0) lineIn = lineIn ^ (4'b1 << $urandom_range(3));
      rdStrobe = ($urandom_range(3) == 0);
      loopMode = ($urandom_range(7) == 0);
      ctrlReg  = 5'($urandom);
      #1 cmpModel();
      step();
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule